// File: doc/BRIEF.md
# Raster Waveform Plot Renderer

This block paints a stored signal as a trace inside a raster video frame. An external timing generator supplies the current scan column, the scan row and an active-video flag. The block turns the column into an address for a sample memory with one cycle of read latency. It then decides, pixel by pixel, whether the pixel sits on the trace, and produces a 9-bit colour word with 3 bits each for red, green and blue.

The plot region is `PLOT_W` columns wide and `PLOT_H` rows tall. It starts at column `PLOT_X0`, and each screen column shows exactly one sample. Row 0 is the top line and rows grow downward, so a sample value is compared directly with the row number. The block has two modes. In the exact mode only the pixel whose row equals the sample is lit. In the interpolating mode the block also keeps the previous column's sample and lights the whole vertical run between the two values, which gives an unbroken trace. A decimation input spreads the columns across the memory with a stride of 1, 2, 4 or 8.

The defaults match a 640x480 frame with a 512x480 plot at the left edge.

Top module: `wave_trace_renderer`

## Requirements
- R1: While `activeIn` is high and the column lies outside [`PLOT_X0`, `PLOT_X0+PLOT_W`), the output colour is `BG_COLOR`.
- R2: `memAddr` is combinational from the current inputs. Inside the plot region it equals (`scanX - PLOT_X0`) shifted left by `decimShift`; outside the region it is 0.
- R3: With `interpEn` = 0, an active pixel inside the region shows `TRACE_COLOR` exactly when its row equals the clamped sample of its column, and shows `BG_COLOR` otherwise.
- R4: With `interpEn` = 1, an active pixel inside the region shows `TRACE_COLOR` when its row lies between the clamped samples of the previous and the current column, inclusive, whichever of the two is larger. Otherwise it shows `BG_COLOR`.
- R5: At column `PLOT_X0`, the previous sample is taken to be equal to the current one.
- R6: A sample above `PLOT_H-1` is treated as `PLOT_H-1` before any comparison.
- R7: While the scan is not active (`activeIn` = 0), the output colour is 0 (black).
- R8: The colour for the inputs sampled at clock edge k appears at the output after edge k+1. One register aligns the scan with the memory data, and a second register holds the output.
- R9: While `rstN` is low, the output colour is 0.
- R10: `decimShift` values 0, 1, 2 and 3 select memory strides of 1, 2, 4 and 8 samples per screen column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Synchronous reset, active low |
| scanX | input | POS_W | Current scan column |
| scanY | input | POS_W | Current scan row |
| activeIn | input | 1 | High inside the visible area |
| interpEn | input | 1 | 1 selects interpolating mode, 0 selects exact mode |
| decimShift | input | SHIFT_W | Stride exponent, giving a stride of 1 << decimShift |
| memAddr | output | ADDR_W | Read address to the sample memory |
| memData | input | SAMP_W | Sample returned one cycle after the address |
| colorOut | output | 9 | Pixel colour {R[2:0], G[2:0], B[2:0]} |

## Verification
The bench builds the block with a 16-column, 20-row plot that starts at column 4, inside a 24x24 visible area and a 28x26 total frame. With this frame size, whole frames in every mode, every stride and every blanking case fit into a few thousand cycles. A plot height of 20 lets 9-bit samples go far above the clamp limit. Because there are only 16 columns, the first-column rule comes up in every frame.

// File: rtl/wtr_pkg.sv
package wtr_pkg;
  localparam int COLOR_W = 9;

  // strobes handed from control to datapath, aligned with memory data
  typedef struct packed {
    logic active;    // scan is in the visible area
    logic inPlot;    // visible and inside the plot columns
    logic firstCol;  // first plot column: no earlier sample exists
  } stb_t;
endpackage

// File: rtl/wtr_ctrl.sv
module wtr_ctrl #(
  parameter int POS_W   = 10,
  parameter int PLOT_X0 = 0,
  parameter int PLOT_W  = 512,
  parameter int SHIFT_W = 2,
  parameter int ADDR_W  = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [POS_W-1:0]    scanX,
  input  logic [POS_W-1:0]    scanY,
  input  logic                activeIn,
  input  logic [SHIFT_W-1:0]  decimShift,
  output logic [ADDR_W-1:0]   memAddr,
  output wtr_pkg::stb_t       stbQ,
  output logic [POS_W-1:0]    rowQ
);
  localparam int COL_W = $clog2(PLOT_W);
  localparam logic [POS_W-1:0] X_LO = POS_W'(PLOT_X0);
  localparam logic [POS_W-1:0] X_HI = POS_W'(PLOT_X0 + PLOT_W);

  logic             inRegion;
  logic [POS_W-1:0] colRaw;

  assign inRegion = (scanX >= X_LO) && (scanX < X_HI);
  assign colRaw   = scanX - X_LO;
  // address requested now, data returns with the delayed strobes
  assign memAddr  = inRegion ? (ADDR_W'(colRaw[COL_W-1:0]) << decimShift) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stbQ <= '0;
      rowQ <= '0;
    end else begin
      stbQ.active   <= activeIn;
      stbQ.inPlot   <= activeIn && inRegion;
      stbQ.firstCol <= activeIn && (scanX == X_LO);
      rowQ          <= scanY;
    end
  end

  // R8: the active flag reaches the datapath one cycle later
  a_r8_active_delay: assert property (@(posedge clk) disable iff (!rstN)
    activeIn |=> stbQ.active);
  // R2: outside the plot no memory column is requested
  a_r2_addr_outside: assert property (@(posedge clk) disable iff (!rstN)
    (scanX < X_LO) |-> (memAddr == '0));
endmodule

// File: rtl/wtr_datapath.sv
module wtr_datapath #(
  parameter int POS_W  = 10,
  parameter int SAMP_W = 9,
  parameter int PLOT_H = 480,
  parameter logic [wtr_pkg::COLOR_W-1:0] TRACE_COLOR = 9'b000_111_000,
  parameter logic [wtr_pkg::COLOR_W-1:0] BG_COLOR    = 9'b001_001_010
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  wtr_pkg::stb_t                 stb,
  input  logic [POS_W-1:0]              rowPos,
  input  logic                          interpEn,
  input  logic [SAMP_W-1:0]             memData,
  output logic [wtr_pkg::COLOR_W-1:0]   colorOut
);
  localparam logic [SAMP_W-1:0] Y_MAX = SAMP_W'(PLOT_H - 1);

  logic [SAMP_W-1:0] curSample, prevSample, prevEff, loVal, hiVal;
  logic              hit;
  logic [wtr_pkg::COLOR_W-1:0] colorNext;

  assign curSample = (memData > Y_MAX) ? Y_MAX : memData;
  assign prevEff   = stb.firstCol ? curSample : prevSample;
  assign loVal     = (prevEff < curSample) ? prevEff : curSample;
  assign hiVal     = (prevEff < curSample) ? curSample : prevEff;

  always_comb begin
    if (interpEn) hit = (rowPos >= POS_W'(loVal)) && (rowPos <= POS_W'(hiVal));
    else          hit = (rowPos == POS_W'(curSample));
    colorNext = '0;
    if (stb.active) colorNext = (stb.inPlot && hit) ? TRACE_COLOR : BG_COLOR;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colorOut   <= '0;
      prevSample <= '0;
    end else begin
      colorOut <= colorNext;
      if (stb.inPlot) prevSample <= curSample;
    end
  end

  // R7: blanking forces black
  a_r7_blank_black: assert property (@(posedge clk) disable iff (!rstN)
    !stb.active |=> (colorOut == '0));
  // R1: active but outside the plot shows background
  a_r1_bg_outside: assert property (@(posedge clk) disable iff (!rstN)
    (stb.active && !stb.inPlot) |=> (colorOut == BG_COLOR));
  // R6: stored previous sample never exceeds the plot height
  a_r6_prev_clamped: assert property (@(posedge clk) disable iff (!rstN)
    prevSample <= Y_MAX);
  // R4: the current sample row is always on the interpolated run
  a_r4_cur_on_run: assert property (@(posedge clk) disable iff (!rstN)
    (stb.inPlot && interpEn && rowPos == POS_W'(curSample)) |=> (colorOut == TRACE_COLOR));
  // R3: exact mode lights the matching row
  a_r3_exact_hit: assert property (@(posedge clk) disable iff (!rstN)
    (stb.inPlot && !interpEn && rowPos == POS_W'(curSample)) |=> (colorOut == TRACE_COLOR));
endmodule

// File: rtl/wave_trace_renderer.sv
module wave_trace_renderer #(
  parameter int POS_W   = 10,
  parameter int SAMP_W  = 9,
  parameter int PLOT_X0 = 0,
  parameter int PLOT_W  = 512,
  parameter int PLOT_H  = 480,
  parameter int SHIFT_W = 2,
  parameter logic [8:0] TRACE_COLOR = 9'b000_111_000,
  parameter logic [8:0] BG_COLOR    = 9'b001_001_010,
  localparam int ADDR_W = $clog2(PLOT_W) + (1 << SHIFT_W) - 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [POS_W-1:0]    scanX,
  input  logic [POS_W-1:0]    scanY,
  input  logic                activeIn,
  input  logic                interpEn,
  input  logic [SHIFT_W-1:0]  decimShift,
  output logic [ADDR_W-1:0]   memAddr,
  input  logic [SAMP_W-1:0]   memData,
  output logic [8:0]          colorOut
);
  wtr_pkg::stb_t    stb;
  logic [POS_W-1:0] rowQ;

  wtr_ctrl #(.POS_W(POS_W), .PLOT_X0(PLOT_X0), .PLOT_W(PLOT_W),
             .SHIFT_W(SHIFT_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .scanX(scanX), .scanY(scanY),
    .activeIn(activeIn), .decimShift(decimShift), .memAddr(memAddr),
    .stbQ(stb), .rowQ(rowQ));

  wtr_datapath #(.POS_W(POS_W), .SAMP_W(SAMP_W), .PLOT_H(PLOT_H),
                 .TRACE_COLOR(TRACE_COLOR), .BG_COLOR(BG_COLOR)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rowPos(rowQ), .interpEn(interpEn),
    .memData(memData), .colorOut(colorOut));
endmodule

// File: tb/wave_trace_renderer_tb.sv
module wave_trace_renderer_tb;
  localparam int X0 = 4, W = 16, H = 20, HT = 28, VT = 26, HA = 24, VA = 24;
  localparam logic [8:0] TRC = 9'b000_111_000, BGC = 9'b001_001_010;
  // table: interpEn, decimShift, sample pattern
  localparam int unsigned VEC [6][3] = '{'{0,0,0}, '{1,0,0}, '{1,0,2},
                                         '{0,1,3}, '{1,3,3}, '{1,2,2}};

  logic clk = 0, rstN = 0, activeIn = 0, interpEn = 0;
  logic [9:0] scanX = 0, scanY = 0;
  logic [1:0] decimShift = 0;
  logic [11:0] memAddr;
  logic [8:0] memData, colorOut;
  int curPat = 1, checks = 0, failures = 0;
  bit done = 0;

  logic [8:0] e0, e1; bit v0 = 0, v1 = 0; string t0, t1;

  always #2 clk = ~clk;

  wave_trace_renderer #(.PLOT_X0(X0), .PLOT_W(W), .PLOT_H(H),
    .TRACE_COLOR(TRC), .BG_COLOR(BGC)) u_dut (
    .clk(clk), .rstN(rstN), .scanX(scanX), .scanY(scanY), .activeIn(activeIn),
    .interpEn(interpEn), .decimShift(decimShift), .memAddr(memAddr),
    .memData(memData), .colorOut(colorOut));

  function automatic int sampleOf(int pat, int addr);
    case (pat)
      0: return (addr * 3) % 32;
      1: return 7;
      2: return (addr % 2 == 1) ? 400 : 2;
      default: return (addr * 5) % 23;
    endcase
  endfunction

  function automatic int clampf(int v);
    return (v > H - 1) ? H - 1 : v;
  endfunction

  always_ff @(posedge clk) memData <= 9'(sampleOf(curPat, int'(memAddr)));

  task automatic check(string req, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic stepPixel(bit act, int x, int y, bit ip, int sh);
    int col, cur, prv, lo, hi; bit lit; logic [8:0] ex; string tg;
    @(negedge clk);
    if (v1) check(t1, 12'(colorOut), 12'(e1));
    e1 = e0; v1 = v0; t1 = t0;
    activeIn = act; scanX = 10'(x); scanY = 10'(y);
    if (!act) begin ex = '0; tg = "R7"; end
    else if (x < X0 || x >= X0 + W) begin ex = BGC; tg = "R1"; end
    else begin
      col = x - X0;
      cur = clampf(sampleOf(curPat, col << sh));
      prv = (col == 0) ? cur : clampf(sampleOf(curPat, (col - 1) << sh));
      lo = (prv < cur) ? prv : cur; hi = (prv < cur) ? cur : prv;
      lit = ip ? (y >= lo && y <= hi) : (y == cur);
      ex = lit ? TRC : BGC;
      tg = ip ? ((col == 0) ? "R5" : "R4") : "R3";
      if (sh != 0) tg = {tg, "/R10"};
      if (curPat == 2) tg = {tg, "/R6"};
    end
    e0 = ex; v0 = 1; t0 = {tg, "/R8"};
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    check("R9", 12'(colorOut), 0);
    rstN = 1;
    @(negedge clk);
    check("R7", 12'(colorOut), 0);
    // R2: address generation
    scanX = 10'(X0 + 5); decimShift = 2; #1;
    check("R2", memAddr, 12'd20);
    scanX = 10'(X0 + 15); decimShift = 3; #1;
    check("R2/R10", memAddr, 12'd120);
    scanX = 10'(X0 + W); #1;
    check("R2", memAddr, 12'd0);
    scanX = 2; #1;
    check("R2", memAddr, 12'd0);
    // R8: latency with pattern 1 (constant 7), exact mode
    curPat = 1; interpEn = 0; decimShift = 0;
    @(negedge clk);
    activeIn = 1; scanX = 10'(X0); scanY = 7;
    @(negedge clk);
    activeIn = 0;
    check("R8", 12'(colorOut), 0);
    @(negedge clk);
    check("R8", 12'(colorOut), 12'(TRC));
    @(negedge clk);
    check("R7", 12'(colorOut), 0);
    // table walk: full frames
    for (int i = 0; i < 6; i++) begin
      interpEn = VEC[i][0][0]; decimShift = 2'(VEC[i][1]); curPat = int'(VEC[i][2]);
      for (int y = 0; y < VT; y++)
        for (int x = 0; x < HT; x++)
          stepPixel(x < HA && y < VA, x, y, VEC[i][0][0], int'(VEC[i][1]));
      for (int k = 0; k < 2; k++) stepPixel(0, HT, 0, 0, 0);
    end
    // R9: reset mid-frame clears the output
    stepPixel(1, X0 + 1, 3, 1, 0);
    @(negedge clk); rstN = 0;
    @(negedge clk);
    check("R9", 12'(colorOut), 0);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule